// File: doc/BRIEF.md
# Packed Pairwise Min/Max Unit

This block folds each of two 64-bit packed operands into half as many elements. Adjacent pairs of elements are reduced to their minimum or their maximum. The reduced elements of the first operand (A) fill the lower half of the result, and those of the second operand (B) fill the upper half. Element width is 8, 16 or 32 bits. The comparison can treat elements as two's-complement or as unsigned. One control bit chooses whether the smaller or the larger member of each pair survives.

A caller places the operands and the three control fields on the inputs and pulses `start_i` for one cycle. On the next clock edge the result is registered and `valid_o` pulses for one cycle. An unsupported width code gives a zero result and raises `bad_size_o` in that same valid cycle. Between operations the result register keeps its last value.

Top module: `pairwise_minmax`

## Requirements
- R1: While `rst_n` is low at a rising edge (synchronous, active-low), the next state has `valid_o`=0, `bad_size_o`=0 and `result_o`=0.
- R2: `valid_o` is 1 in exactly the cycle after a cycle with `start_i`=1, and 0 after any cycle with `start_i`=0.
- R3: With `esize_i`=0 (8-bit elements), result byte k (bits 8k+7..8k, lane 0 least significant) for k=0..3 is the pick of A bytes 2k and 2k+1, and for k=4..7 it is the pick of B bytes 2(k-4) and 2(k-4)+1.
- R4: With `esize_i`=1 (16-bit elements), result halfwords 0..1 come from the pairs of A halfwords (0,1) and (2,3), and halfwords 2..3 come from the same pairs of B.
- R5: With `esize_i`=2 (32-bit elements), result bits 31..0 are the pick of the two 32-bit words of A, and bits 63..32 are the pick of the two words of B.
- R6: With `take_min_i`=1 each pick is the smaller element of its pair. With `take_min_i`=0 it is the larger.
- R7: With `signed_i`=1 elements compare as two's-complement, and with `signed_i`=0 they compare as unsigned.
- R8: When the two elements of a pair are equal, the pick is that value in both min and max mode.
- R9: With `esize_i`=3, the cycle after start has `valid_o`=1, `bad_size_o`=1 and `result_o`=0. `bad_size_o` is never 1 without `valid_o`.
- R10: After a cycle with `start_i`=0, `result_o` keeps the value it had.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts one operation on the current inputs |
| opa_i | input | 64 | Packed operand A, source of the lower result half |
| opb_i | input | 64 | Packed operand B, source of the upper result half |
| esize_i | input | 2 | Element width: 0=8, 1=16, 2=32, 3=illegal |
| take_min_i | input | 1 | 1 keeps the smaller element of each pair, 0 the larger |
| signed_i | input | 1 | 1 compares as two's-complement, 0 as unsigned |
| result_o | output | 64 | Registered packed result |
| valid_o | output | 1 | One-cycle pulse, the cycle after start |
| bad_size_o | output | 1 | Illegal width code flag, shown together with valid |

## Verification
Every result, the valid pulse and the illegal-size flag are due exactly one rising edge after the cycle in which `start_i` is sampled high. The bench drives inputs on the falling edge. Its reference model captures its expectation at the rising edge, and the bench compares at the following falling edge, so every output is checked one cycle after its stimulus and in every cycle, including idle cycles where the held result must not move. Directed operations with literal expected words back this up for the ordering, sign, equal-pair and illegal-code cases.

// File: rtl/pmm_pkg.sv
package pmm_pkg;

    localparam int PMM_DATA_W    = 64;
    localparam int PMM_MIN_ELEM  = 8;
    localparam int PMM_NUM_SIZES = 3;

    typedef enum logic [1:0] {
        ESZ_8   = 2'd0,
        ESZ_16  = 2'd1,
        ESZ_32  = 2'd2,
        ESZ_BAD = 2'd3
    } esize_e;

    typedef struct packed {
        logic                  valid;
        logic                  bad;
        logic [PMM_DATA_W-1:0] result;
    } pmm_state_t;

endpackage

// File: rtl/pmm_pair_pick.sv
// Chooses one element out of a pair: the smaller or the larger one,
// under a signed or unsigned ordering.
module pmm_pair_pick #(
    parameter int ELEM_W = 8
) (
    input  logic [ELEM_W-1:0] lo_i,
    input  logic [ELEM_W-1:0] hi_i,
    input  logic              take_min_i,
    input  logic              signed_i,
    output logic [ELEM_W-1:0] pick_o
);
    localparam int EXT_W = ELEM_W + 1;

    logic [EXT_W-1:0] lo_ext;
    logic [EXT_W-1:0] hi_ext;
    logic             lo_less;

    always_comb begin
        // A single extra top bit turns both orderings into one signed compare.
        lo_ext  = {signed_i & lo_i[ELEM_W-1], lo_i};
        hi_ext  = {signed_i & hi_i[ELEM_W-1], hi_i};
        lo_less = $signed(lo_ext) < $signed(hi_ext);
        if (take_min_i) begin
            pick_o = lo_less ? lo_i : hi_i;
        end else begin
            pick_o = lo_less ? hi_i : lo_i;
        end
    end

endmodule

// File: rtl/pmm_width_bank.sv
// Folds both operands at one fixed element width. The lower half of the
// output comes from operand A and the upper half from operand B.
module pmm_width_bank #(
    parameter int DATA_W = 64,
    parameter int ELEM_W = 8
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              take_min_i,
    input  logic              signed_i,
    output logic [DATA_W-1:0] folded_o
);
    localparam int PAIRS = DATA_W / (2 * ELEM_W);

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        pmm_pair_pick #(.ELEM_W(ELEM_W)) u_pick_a (
            .lo_i       (opa_i[(2*p)*ELEM_W +: ELEM_W]),
            .hi_i       (opa_i[(2*p+1)*ELEM_W +: ELEM_W]),
            .take_min_i (take_min_i),
            .signed_i   (signed_i),
            .pick_o     (folded_o[p*ELEM_W +: ELEM_W])
        );
        pmm_pair_pick #(.ELEM_W(ELEM_W)) u_pick_b (
            .lo_i       (opb_i[(2*p)*ELEM_W +: ELEM_W]),
            .hi_i       (opb_i[(2*p+1)*ELEM_W +: ELEM_W]),
            .take_min_i (take_min_i),
            .signed_i   (signed_i),
            .pick_o     (folded_o[(PAIRS+p)*ELEM_W +: ELEM_W])
        );
    end

endmodule

// File: rtl/pairwise_minmax.sv
module pairwise_minmax
    import pmm_pkg::*;
#(
    parameter int DATA_W    = PMM_DATA_W,
    parameter int MIN_ELEM  = PMM_MIN_ELEM,
    parameter int NUM_SIZES = PMM_NUM_SIZES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [63:0]       opa_i,
    input  logic [63:0]       opb_i,
    input  logic [1:0]        esize_i,
    input  logic              take_min_i,
    input  logic              signed_i,
    output logic [63:0]       result_o,
    output logic              valid_o,
    output logic              bad_size_o
);
    localparam int WORD_W = DATA_W / 2;

    // One bank per legal element width, all evaluated in parallel.
    logic [DATA_W-1:0] folded [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_bank
        pmm_width_bank #(
            .DATA_W (DATA_W),
            .ELEM_W (MIN_ELEM << g)
        ) u_bank (
            .opa_i      (opa_i),
            .opb_i      (opb_i),
            .take_min_i (take_min_i),
            .signed_i   (signed_i),
            .folded_o   (folded[g])
        );
    end

    pmm_state_t st_d;
    pmm_state_t st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.bad   = 1'b0;
        if (start_i) begin
            st_d.valid = 1'b1;
            unique case (esize_e'(esize_i))
                ESZ_8:   st_d.result = folded[0];
                ESZ_16:  st_d.result = folded[1];
                ESZ_32:  st_d.result = folded[2];
                default: begin
                    st_d.result = '0;
                    st_d.bad    = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o   = st_q.result;
    assign valid_o    = st_q.valid;
    assign bad_size_o = st_q.bad;

    // Valid follows start by exactly one cycle.
    p_valid_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);
    p_quiet_without_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !valid_o);

    // Illegal code: flag only with valid, and a zero result.
    p_bad_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_size_o |-> valid_o);
    p_bad_zero_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && esize_i == 2'd3) |=> (bad_size_o && result_o == '0));

    // The result register holds while idle.
    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(result_o));

    // Unsigned 32-bit min never exceeds either source word of A.
    p_min_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && esize_i == 2'd2 && take_min_i && !signed_i) |=>
        (result_o[WORD_W-1:0] <= $past(opa_i[WORD_W-1:0]) &&
         result_o[WORD_W-1:0] <= $past(opa_i[DATA_W-1:WORD_W])));

    // Equal 32-bit words in A come through unchanged.
    p_equal_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && esize_i == 2'd2 && opa_i[WORD_W-1:0] == opa_i[DATA_W-1:WORD_W]) |=>
        (result_o[WORD_W-1:0] == $past(opa_i[WORD_W-1:0])));

endmodule

// File: tb/pairwise_minmax_tb_top.sv
module pairwise_minmax_tb_top;

    localparam int MAX_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic [1:0]  esize_i = '0;
    logic        take_min_i = 1'b0;
    logic        signed_i = 1'b0;
    logic [63:0] result_o;
    logic        valid_o;
    logic        bad_size_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit model_on = 1'b0;

    always #2 clk = ~clk;

    pairwise_minmax dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .esize_i    (esize_i),
        .take_min_i (take_min_i),
        .signed_i   (signed_i),
        .result_o   (result_o),
        .valid_o    (valid_o),
        .bad_size_o (bad_size_o)
    );

    // Behavioural reference for one operation.
    function automatic logic [63:0] ref_fold(logic [63:0] a, logic [63:0] b,
                                             logic [1:0] sz, logic mn, logic sg);
        logic [63:0] res;
        int w;
        int n;
        longint mask;
        res = '0;
        if (sz == 2'd3) return '0;
        w = 8 << sz;
        n = 64 / w;
        mask = (longint'(1) << w) - 1;
        for (int k = 0; k < n; k++) begin
            logic [63:0] src;
            int j;
            longint x;
            longint y;
            longint xs;
            longint ys;
            longint pick;
            src = (k < n / 2) ? a : b;
            j = (k < n / 2) ? k : k - n / 2;
            x = longint'(src >> (2 * j * w)) & mask;
            y = longint'(src >> ((2 * j + 1) * w)) & mask;
            xs = x;
            ys = y;
            if (sg) begin
                if (((x >> (w - 1)) & 1) != 0) xs = x - (longint'(1) << w);
                if (((y >> (w - 1)) & 1) != 0) ys = y - (longint'(1) << w);
            end
            if (mn) pick = (xs <= ys) ? x : y;
            else    pick = (xs >= ys) ? x : y;
            res = res | (64'(pick) << (k * w));
        end
        return res;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Cycle model: expectations captured at the rising edge.
    logic        m_valid = 1'b0;
    logic        m_bad = 1'b0;
    logic [63:0] m_result = '0;
    logic [1:0]  m_size = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid  = 1'b0;
            m_bad    = 1'b0;
            m_result = '0;
        end else begin
            m_valid = start_i;
            m_bad   = start_i && (esize_i == 2'd3);
            if (start_i) begin
                m_result = ref_fold(opa_i, opb_i, esize_i, take_min_i, signed_i);
                m_size   = esize_i;
            end
        end
    end

    always @(negedge clk) begin
        if (model_on && !finished) begin
            chk("R2 valid", 64'(valid_o), 64'(m_valid));
            chk("R9 bad_size", 64'(bad_size_o), 64'(m_bad));
            if (!m_valid)             chk("R10 held result", result_o, m_result);
            else if (m_size == 2'd0)  chk("R3 8-bit result", result_o, m_result);
            else if (m_size == 2'd1)  chk("R4 16-bit result", result_o, m_result);
            else if (m_size == 2'd2)  chk("R5 32-bit result", result_o, m_result);
            else                      chk("R9 zero result", result_o, m_result);
        end
    end

    task automatic run_op(logic [63:0] a, logic [63:0] b, logic [1:0] sz,
                          logic mn, logic sg, logic [63:0] exp, string tag);
        @(negedge clk);
        opa_i = a; opb_i = b; esize_i = sz; take_min_i = mn; signed_i = sg;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(tag, result_o, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid", 64'(valid_o), 64'd0);
        chk("R1 bad_size", 64'(bad_size_o), 64'd0);
        chk("R1 result", result_o, 64'd0);
        rst_n = 1'b1;
        model_on = 1'b1;

        // R6: min versus max on bytes
        run_op(64'h0807060504030201, 64'h1011121314151617, 2'd0, 1'b1, 1'b0,
               64'h1012141607050301, "R6 byte min");
        run_op(64'h0807060504030201, 64'h1011121314151617, 2'd0, 1'b0, 1'b0,
               64'h1113151708060402, "R6 byte max");
        // R7: signed versus unsigned on halfwords
        run_op(64'h7FFF80000001FFFF, 64'h0, 2'd1, 1'b0, 1'b1,
               64'h000000007FFF0001, "R7 signed max");
        run_op(64'h7FFF80000001FFFF, 64'h0, 2'd1, 1'b0, 1'b0,
               64'h000000008000FFFF, "R7 unsigned max");
        // R8: equal words, both modes
        run_op(64'hDEADBEEFDEADBEEF, 64'h1234567812345678, 2'd2, 1'b1, 1'b1,
               64'h12345678DEADBEEF, "R8 equal min");
        run_op(64'hDEADBEEFDEADBEEF, 64'h1234567812345678, 2'd2, 1'b0, 1'b0,
               64'h12345678DEADBEEF, "R8 equal max");
        // R9: illegal width code
        run_op(64'hFFFFFFFFFFFFFFFF, 64'h0123456789ABCDEF, 2'd3, 1'b1, 1'b0,
               64'h0, "R9 illegal code result");
        // R10: idle cycles keep result
        repeat (3) @(negedge clk);

        // Random traffic with gaps and back-to-back starts.
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            opa_i      = {$urandom, $urandom};
            opb_i      = {$urandom, $urandom};
            esize_i    = 2'($urandom % 4);
            take_min_i = 1'($urandom);
            signed_i   = 1'($urandom);
            start_i    = ($urandom % 4) != 0;
        end
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);

        // R1: reset in the middle of traffic
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule